// File: doc/BRIEF.md
# Complex Fixed-Point Multiply-Accumulate Unit

This block forms dot products of complex numbers. Each clock it can take one multiplicand element and one multiplier element, multiply them as complex numbers, and add the product into a running complex sum. Every element is a 32-bit word that holds two 16-bit two's-complement parts. The multiplicand parts carry 14 fraction bits and lie in the range -1 to +1. The multiplier parts and the result parts share one fixed-point format. The sum is kept wide and with full precision. It is scaled back into the result format only when the block reads it out.

A sequencer drives one beat per cycle. A clear beat loads the sum with a starting result element, for example a partial product from an earlier pass. A valid beat adds a product term. A last beat asks for the sum, which appears as one packed word with a single-cycle strobe. The sum is not emptied by a read, so the sequencer can read a running total more than once.

Top module: `cmac_unit`

## Requirements
- R1: Every element packs the real part in bits 31:16 and the imaginary part in bits 15:0, each 16-bit two's complement; the result word uses the same packing.
- R2: Multiplicand parts have 14 fraction bits, so a multiplicand of 0x4000 in the real part and 0 in the imaginary part (one) returns the multiplier unchanged.
- R3: The real term is ar*br - ai*bi and the imaginary term is ar*bi + ai*br, each product formed at full 32-bit precision.
- R4: Terms add into a guard-extended sum at full precision, so terms that each scale to zero still add up to a nonzero result.
- R5: A beat with in_clear high loads the sum with in_init shifted into the sum's scale; if in_valid is also high, that beat's term is added on top of it.
- R6: A beat with in_valid and in_clear low leaves the sum unchanged, whatever in_a and in_b carry.
- R7: A beat with in_last high raises out_valid for one cycle exactly three clock edges later, and out_data then holds the sum including that beat's own clear and term. out_data holds its value while out_valid is low.
- R8: Beats are accepted on every cycle with no gaps, and each beat's term is counted once.
- R9: On readout each part of the sum is shifted right arithmetically by 14 and truncated to 16 bits, so a sum of -1 LSB reads as 0xFFFF (rounding toward minus infinity).
- R10: After reset out_valid is 0, out_data is 0 and the sum is zero.
- R11: A readout does not clear the sum. Later terms keep adding to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Add the product of in_a and in_b this beat |
| in_clear | input | 1 | Load the sum from in_init this beat |
| in_last | input | 1 | Read the sum out after this beat |
| in_init | input | 32 | Starting result element used with in_clear |
| in_a | input | 32 | Multiplicand element, 14 fraction bits per part |
| in_b | input | 32 | Multiplier element |
| out_valid | output | 1 | One-cycle strobe that marks out_data as new |
| out_data | output | 32 | Packed result element |

## Verification
The bench targets four corner cases:
- **Identity multiply:** a design that scaled by the wrong shift would not return the multiplier unchanged.
- **Pure imaginary multiplicand:** this exposes swapped parts or a wrong sign on the ai*bi term.
- **Many sub-LSB terms:** these only count if the sum keeps its low bits, so early truncation would read 0.
- **Negative sum of one LSB:** this must read as all ones, so rounding toward zero would be caught.

Bubbles with busy operand buses, a clear combined with a term, repeated readouts without clear, and long random back-to-back runs check that no beat is lost, counted twice or leaks in while idle.

// File: rtl/cmac_pkg.sv
package cmac_pkg;
   // part positions inside a packed element: real is the upper half
   localparam int unsigned RE_IDX  = 1;
   localparam int unsigned IM_IDX  = 0;
   localparam int unsigned N_PARTS = 2;
   localparam int unsigned N_PROD  = 4;

   // product k: 0 = re*re, 1 = im*im, 2 = re*im, 3 = im*re
   function automatic int unsigned a_part_of(input int unsigned k);
      return (k == 1 || k == 3) ? IM_IDX : RE_IDX;
   endfunction

   function automatic int unsigned b_part_of(input int unsigned k);
      return (k == 1 || k == 2) ? IM_IDX : RE_IDX;
   endfunction
endpackage

// File: rtl/cmac_mult.sv
module cmac_mult
   import cmac_pkg::*;
#(
   parameter int unsigned PART_W = 16,
   localparam int unsigned ELEM_W = N_PARTS * PART_W,
   localparam int unsigned PROD_W = 2 * PART_W
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [ELEM_W-1:0]              a_i,
   input  logic [ELEM_W-1:0]              b_i,
   output logic [N_PROD-1:0][PROD_W-1:0]  prod_o
);
   logic [N_PARTS-1:0][PART_W-1:0] a_p, b_p;
   assign a_p = a_i;
   assign b_p = b_i;

   for (genvar k = 0; k < N_PROD; k++) begin : g_prod
      localparam int unsigned AI = a_part_of(k);
      localparam int unsigned BI = b_part_of(k);
      logic signed [PROD_W-1:0] full;
      assign full = PROD_W'($signed(a_p[AI])) * PROD_W'($signed(b_p[BI]));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) prod_o[k] <= '0;
         else        prod_o[k] <= full;
      end
   end
endmodule

// File: rtl/cmac_accum.sv
module cmac_accum
   import cmac_pkg::*;
#(
   parameter int unsigned PART_W  = 16,
   parameter int unsigned FRAC_W  = 14,
   parameter int unsigned GUARD_W = 8,
   localparam int unsigned ELEM_W = N_PARTS * PART_W,
   localparam int unsigned PROD_W = 2 * PART_W,
   localparam int unsigned ACC_W  = PROD_W + 1 + GUARD_W
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           en_i,
   input  logic                           clr_i,
   input  logic                           last_i,
   input  logic [ELEM_W-1:0]              init_i,
   input  logic [N_PROD-1:0][PROD_W-1:0]  prod_i,
   output logic                           out_valid_o,
   output logic [ELEM_W-1:0]              out_data_o
);
   logic [N_PARTS-1:0][PART_W-1:0] init_p;
   logic [N_PARTS-1:0][PART_W-1:0] res_p;
   logic signed [ACC_W-1:0] term [N_PARTS];

   assign init_p = init_i;
   assign term[RE_IDX] = ACC_W'($signed(prod_i[0])) - ACC_W'($signed(prod_i[1]));
   assign term[IM_IDX] = ACC_W'($signed(prod_i[2])) + ACC_W'($signed(prod_i[3]));

   for (genvar j = 0; j < N_PARTS; j++) begin : g_lane
      logic signed [ACC_W-1:0] acc_q, base, nxt;
      always_comb begin
         base = clr_i ? (ACC_W'($signed(init_p[j])) <<< FRAC_W) : acc_q;
         nxt  = base + (en_i ? term[j] : '0);
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            acc_q    <= '0;
            res_p[j] <= '0;
         end else begin
            acc_q <= nxt;
            if (last_i) res_p[j] <= nxt[FRAC_W +: PART_W];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) out_valid_o <= 1'b0;
      else        out_valid_o <= last_i;
   end
   assign out_data_o = res_p;
endmodule

// File: rtl/cmac_unit.sv
module cmac_unit
   import cmac_pkg::*;
#(
   parameter int unsigned PART_W  = 16,
   parameter int unsigned FRAC_W  = 14,
   parameter int unsigned GUARD_W = 8,
   localparam int unsigned ELEM_W = N_PARTS * PART_W,
   localparam int unsigned PROD_W = 2 * PART_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              in_clear,
   input  logic              in_last,
   input  logic [ELEM_W-1:0] in_init,
   input  logic [ELEM_W-1:0] in_a,
   input  logic [ELEM_W-1:0] in_b,
   output logic              out_valid,
   output logic [ELEM_W-1:0] out_data
);
   if (FRAC_W >= PART_W) begin : g_bad_frac
      $error("FRAC_W must be below PART_W");
   end
   if (GUARD_W < 1) begin : g_bad_guard
      $error("GUARD_W must be at least one");
   end

   // stage 1: operand and control capture
   logic              s1_v, s1_c, s1_l;
   logic [ELEM_W-1:0] s1_a, s1_b, s1_init;
   // stage 2: control aligned with registered products
   logic              s2_v, s2_c, s2_l;
   logic [ELEM_W-1:0] s2_init;
   logic [N_PROD-1:0][PROD_W-1:0] s2_prod;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         {s1_v, s1_c, s1_l} <= '0;
         {s2_v, s2_c, s2_l} <= '0;
         s1_a    <= '0;
         s1_b    <= '0;
         s1_init <= '0;
         s2_init <= '0;
      end else begin
         {s1_v, s1_c, s1_l} <= {in_valid, in_clear, in_last};
         s1_a    <= in_a;
         s1_b    <= in_b;
         s1_init <= in_init;
         {s2_v, s2_c, s2_l} <= {s1_v, s1_c, s1_l};
         s2_init <= s1_init;
      end
   end

   cmac_mult #(.PART_W(PART_W)) u_mult (
      .clk    (clk),
      .rst_n  (rst_n),
      .a_i    (s1_a),
      .b_i    (s1_b),
      .prod_o (s2_prod)
   );

   cmac_accum #(.PART_W(PART_W), .FRAC_W(FRAC_W), .GUARD_W(GUARD_W)) u_acc (
      .clk         (clk),
      .rst_n       (rst_n),
      .en_i        (s2_v),
      .clr_i       (s2_c),
      .last_i      (s2_l),
      .init_i      (s2_init),
      .prod_i      (s2_prod),
      .out_valid_o (out_valid),
      .out_data_o  (out_data)
   );
endmodule

// File: rtl/cmac_unit_chk.sv
module cmac_unit_chk #(
   parameter int unsigned PART_W = 16,
   localparam int unsigned ELEM_W = 2 * PART_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              in_clear,
   input logic              in_last,
   input logic [ELEM_W-1:0] in_init,
   input logic [ELEM_W-1:0] in_a,
   input logic [ELEM_W-1:0] in_b,
   input logic              out_valid,
   input logic [ELEM_W-1:0] out_data
);
   AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> !out_valid); // R10

   AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      in_last |-> ##3 out_valid); // R7

   AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> $stable(out_data)); // R7

   AST_CLEAR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (in_clear && in_last && !in_valid) |-> ##3 (out_data == $past(in_init, 3))); // R5

   AST_ZERO_TERM: assert property (@(posedge clk) disable iff (!rst_n)
      (in_clear && in_last && in_valid && in_a == '0) |-> ##3 (out_data == $past(in_init, 3))); // R3
endmodule

bind cmac_unit cmac_unit_chk #(.PART_W(PART_W)) chk_i (.*);

// File: tb/cmac_unit_tb.sv
module cmac_unit_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0, in_clear = 1'b0, in_last = 1'b0;
   logic [31:0] in_init = '0, in_a = '0, in_b = '0;
   logic        out_valid;
   logic [31:0] out_data;

   int    n_vec = 0;
   int    n_bad = 0;
   bit    done  = 1'b0;
   longint acc_re = 0, acc_im = 0;
   bit    ev [1:3];
   logic [31:0] ed [1:3];
   string etag [1:3];

   always #10 clk = ~clk;

   cmac_unit dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_clear(in_clear),
      .in_last(in_last), .in_init(in_init), .in_a(in_a), .in_b(in_b),
      .out_valid(out_valid), .out_data(out_data)
   );

   function automatic longint sx(input logic [15:0] x);
      return longint'($signed(x));
   endfunction

   function automatic logic [15:0] rd(input longint s);
      longint t;
      t = s >>> 14;
      return t[15:0];
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic beat(input bit v, input bit c, input bit l,
                       input logic [31:0] init, input logic [31:0] a,
                       input logic [31:0] b, input string tag);
      @(negedge clk);
      check({etag[3], " valid"}, {31'd0, out_valid}, {31'd0, ev[3]});
      if (ev[3]) check({etag[3], " data"}, out_data, ed[3]);
      for (int s = 3; s > 1; s--) begin
         ev[s] = ev[s-1]; ed[s] = ed[s-1]; etag[s] = etag[s-1];
      end
      in_valid = v; in_clear = c; in_last = l;
      in_init = init; in_a = a; in_b = b;
      if (c) begin
         acc_re = sx(init[31:16]) <<< 14;
         acc_im = sx(init[15:0]) <<< 14;
      end
      if (v) begin
         acc_re += sx(a[31:16]) * sx(b[31:16]) - sx(a[15:0]) * sx(b[15:0]);
         acc_im += sx(a[31:16]) * sx(b[15:0]) + sx(a[15:0]) * sx(b[31:16]);
      end
      ev[1] = l; ed[1] = {rd(acc_re), rd(acc_im)}; etag[1] = tag;
   endtask

   task automatic drain();
      for (int i = 0; i < 3; i++) beat(0, 0, 0, '0, '0, '0, "drain");
   endtask

   function automatic logic [31:0] rand_a();
      int r, m;
      r = int'($urandom_range(32768)) - 16384;
      m = int'($urandom_range(32768)) - 16384;
      return {r[15:0], m[15:0]};
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd2024));
      for (int s = 1; s <= 3; s++) begin ev[s] = 0; ed[s] = '0; etag[s] = "idle"; end
      repeat (3) @(negedge clk);
      check("R10 reset valid", {31'd0, out_valid}, 32'd0);
      check("R10 reset data", out_data, 32'd0);
      @(negedge clk); rst_n = 1'b1;

      // R10: read an untouched sum
      beat(0, 0, 1, '0, '0, '0, "R10 zero sum");
      // R5: plain load and read back
      beat(0, 1, 1, 32'h1234_ABCD, 32'hFFFF_FFFF, 32'h7FFF_7FFF, "R5 load");
      // R2 R1: one times b
      beat(1, 1, 1, '0, 32'h4000_0000, 32'h0123_FF00, "R2 identity");
      drain();
      check("R1 identity direct", out_data, 32'h0123_FF00);
      // R3: pure imaginary multiplicand, b = 3 + 5j -> -5 + 3j
      beat(1, 1, 1, '0, 32'h0000_4000, 32'h0003_0005, "R3 rotate");
      drain();
      check("R3 rotate direct", out_data, 32'hFFFB_0003);
      // R4: two sub-LSB terms sum to one LSB
      beat(1, 1, 0, '0, 32'h0001_0000, 32'h2000_0000, "R4 part1");
      beat(1, 0, 1, '0, 32'h0001_0000, 32'h2000_0000, "R4 sum");
      drain();
      check("R4 direct", out_data, 32'h0001_0000);
      // R9: -1 LSB floors to all ones
      beat(1, 1, 1, '0, 32'hFFFF_0000, 32'h0001_0000, "R9 floor");
      drain();
      check("R9 direct", out_data, 32'hFFFF_0000);
      // R6: bubbles with busy buses; R11: read twice without clear
      beat(1, 1, 1, 32'h0010_0020, 32'h4000_0000, 32'h0001_0001, "R11 first read");
      beat(0, 0, 0, '0, 32'h3FFF_3FFF, 32'h7FFF_7FFF, "R6 bubble");
      beat(0, 0, 1, '0, 32'hC000_4000, 32'h1234_5678, "R6 bubble read");
      beat(1, 0, 1, '0, 32'h4000_0000, 32'h0002_0003, "R11 second read");
      // R5 with term on the same beat
      beat(1, 1, 1, 32'h0100_0200, 32'h4000_0000, 32'h0001_0001, "R5 load plus term");
      // R8 R7: random back-to-back runs
      for (int run = 0; run < 300; run++) begin
         int len;
         len = int'($urandom_range(8, 1));
         for (int i = 0; i < len; i++) begin
            bit clr, lst, v;
            clr = (i == 0);
            lst = (i == len - 1);
            v   = ($urandom_range(7) != 0);
            beat(v, clr, lst, $urandom(), rand_a(), $urandom(), "R8 random run");
         end
      end
      drain();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule